// File: doc/BRIEF.md
# Conversion Sequencer for a Multichannel Converter

This block decides which analog channel a shared conversion engine samples next. It keeps two programmable lists of channel numbers. The regular list has up to sixteen slots and the injected list has up to four. Each list has a length field, and a channel number may appear in any slot and in any order. A run of either list starts on a software start pulse or on an external trigger edge. Each list has its own edge selection. The block gives each slot in turn to the engine. It raises a one-cycle request that carries the channel number. The engine answers with a done pulse and the converted value.

Regular results share one data register, and software marks that register as read. Each injected slot writes its result to its own register, indexed by slot position. Several options shape a regular run: converting slot 0 alone or the whole list, restarting without end, and splitting the list into chunks with one chunk per trigger. The injected list can interrupt the regular list at a conversion boundary, or it can follow the regular list automatically. Three sticky flags report progress: end of conversion, end of the injected list, and overrun. Hardware sets these flags and software clears them.

Top module: `conv_sequencer`

## Requirements
- R1: After reset no request is raised, the regular data register, all four injected registers and all three flags are zero.
- R2: An edge field selects what an external trigger line does: 00 ignores the line, 01 starts a run on a rising edge, 10 on a falling edge, 11 on either edge. The regular and injected groups each have their own line and field, and a software start pulse starts its group whatever the field holds.
- R3: With scan off a regular run converts slot 0 only. With scan on it converts slots 0 to the programmed length in slot order. Each request is a one-cycle pulse that carries the slot's channel, and the next request comes only after the engine's done pulse.
- R4: With repeat on (and chunking off) a regular run that reaches its last slot starts again at slot 0. When repeat is cleared the run stops at the end of the list in progress.
- R5: With chunking on, each regular trigger converts the next (chunk_m1 + 1) slots, or fewer if the list ends first. The trigger after the one that reaches the last slot starts again at slot 0.
- R6: An injected start during a regular run lets the regular conversion in flight complete. The whole injected list runs next, and the regular run then continues at the following slot.
- R7: With inject-after-regular set, the injected list runs right after every regular run that reaches the end of the regular list, and injected starts and triggers are ignored.
- R8: With injected stepping on, each injected start converts exactly one injected slot. It takes the next slot and wraps to slot 0 after the last one.
- R9: A regular result goes to the regular data register. The result of injected slot k goes to bits [12k+11:12k] of the injected data bus.
- R10: With eoc_per_conv = 1 the end-of-conversion flag is set after every regular conversion. With 0 it is set only after the last slot of the regular list (slot 0 when scan is off).
- R11: The injected-end flag is set when the last injected slot completes.
- R12: The overrun flag is set when a regular result is written while the previous one is still unread. A dr_read pulse marks the register read, and a read in the same cycle as a write counts as a read of the older value.
- R13: Each flag stays set until its clear input is pulsed. A set and a clear in the same cycle leave the flag set.
- R14: A regular start that arrives while a regular run is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_en | input | 1 | Convert the whole regular list instead of slot 0 only |
| repeat_en | input | 1 | Restart the regular list when it ends |
| chunk_en | input | 1 | Split the regular list into chunks, one per trigger |
| chunk_m1 | input | 3 | Chunk size minus one |
| inj_step_en | input | 1 | One injected slot per injected start |
| inj_after_reg | input | 1 | Run the injected list after each completed regular list |
| eoc_per_conv | input | 1 | End-of-conversion flag per conversion (1) or per list (0) |
| reg_len | input | 4 | Index of the last regular slot |
| reg_seq | input | 80 | Regular channel slots, slot i at bits [5i+4:5i] |
| inj_len | input | 2 | Index of the last injected slot |
| inj_seq | input | 20 | Injected channel slots, slot i at bits [5i+4:5i] |
| reg_edge | input | 2 | Regular trigger edge select |
| inj_edge | input | 2 | Injected trigger edge select |
| reg_sw_start | input | 1 | Software start pulse, regular group |
| inj_sw_start | input | 1 | Software start pulse, injected group |
| reg_ext_trig | input | 1 | External trigger line, regular group |
| inj_ext_trig | input | 1 | External trigger line, injected group |
| conv_req | output | 1 | One-cycle conversion request |
| conv_ch | output | 5 | Channel of the current request |
| conv_done | input | 1 | Engine completion pulse |
| conv_data | input | 12 | Converted value, valid with conv_done |
| reg_data | output | 12 | Last regular result |
| inj_data | output | 48 | Injected results, slot k at bits [12k+11:12k] |
| dr_read | input | 1 | Marks the regular result as read |
| eoc | output | 1 | End-of-conversion flag |
| inj_eoc | output | 1 | Injected-list-end flag |
| overrun | output | 1 | Regular result lost flag |
| eoc_clr | input | 1 | Clears eoc |
| inj_eoc_clr | input | 1 | Clears inj_eoc |
| overrun_clr | input | 1 | Clears overrun |

## Verification
The embedded properties assume that the engine pulses conv_done once for each request and only while a conversion is outstanding. They also assume that list lengths and the chunk size stay fixed while a run is active. The bench models the engine as a responder with a fixed latency that answers each request exactly once. It changes configuration only after a settling interval has let every run end, and it issues the mid-run starts for the preemption and ignore cases only while a conversion is known to be in flight.

// File: rtl/seq_pkg.sv
package seq_pkg;

    localparam int CH_W_DEF      = 5;
    localparam int DATA_W_DEF    = 12;
    localparam int REG_SLOTS_DEF = 16;
    localparam int INJ_SLOTS_DEF = 4;
    localparam int CHUNK_W_DEF   = 3;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_e;

    typedef enum logic {
        GRP_REG = 1'b0,
        GRP_INJ = 1'b1
    } group_e;

    typedef struct packed {
        logic wr_reg;
        logic wr_inj;
        logic reg_list_end;
        logic inj_list_end;
    } done_evt_t;

    function automatic logic edge_hit(input logic [1:0] mode, input logic prev, input logic cur);
        logic rise;
        logic fall;
        rise = cur & ~prev;
        fall = prev & ~cur;
        case (edge_mode_e'(mode))
            EDGE_RISE: edge_hit = rise;
            EDGE_FALL: edge_hit = fall;
            EDGE_BOTH: edge_hit = rise | fall;
            default:   edge_hit = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/seq_trig_edge.sv
module seq_trig_edge
    import seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode,
    input  logic       ext_in,
    input  logic       sw_in,
    output logic       go
);

    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= ext_in;
    end

    assign go = sw_in | edge_hit(mode, prev_q, ext_in);

endmodule

// File: rtl/seq_sched.sv
module seq_sched
    import seq_pkg::*;
#(
    parameter int CH_W      = CH_W_DEF,
    parameter int REG_SLOTS = REG_SLOTS_DEF,
    parameter int INJ_SLOTS = INJ_SLOTS_DEF,
    parameter int CHUNK_W   = CHUNK_W_DEF,
    localparam int RIDX_W   = $clog2(REG_SLOTS),
    localparam int IIDX_W   = $clog2(INJ_SLOTS)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      scan_en,
    input  logic                      repeat_en,
    input  logic                      chunk_en,
    input  logic [CHUNK_W-1:0]        chunk_m1,
    input  logic                      inj_step_en,
    input  logic                      inj_after_reg,
    input  logic [RIDX_W-1:0]         reg_len,
    input  logic [REG_SLOTS*CH_W-1:0] reg_seq,
    input  logic [IIDX_W-1:0]         inj_len,
    input  logic [INJ_SLOTS*CH_W-1:0] inj_seq,
    input  logic                      reg_go,
    input  logic                      inj_go,
    input  logic                      conv_done,
    output logic                      conv_req,
    output logic [CH_W-1:0]           conv_ch,
    output done_evt_t                 evt,
    output logic [IIDX_W-1:0]         evt_slot
);

    logic              busy;
    group_e            cur_grp;
    logic              reg_run;
    logic              inj_run;
    logic [RIDX_W-1:0] reg_idx;
    logic [IIDX_W-1:0] inj_idx;
    logic [CHUNK_W-1:0] reg_cnt;

    logic reg_last;
    logic inj_last;
    logic chunk_end;
    logic issue;
    logic finish;
    logic keep_going;

    assign reg_last   = !scan_en || (reg_idx == reg_len);
    assign inj_last   = (inj_idx == inj_len);
    assign chunk_end  = chunk_en && (reg_cnt == chunk_m1);
    assign issue      = !busy && (inj_run || reg_run);
    assign finish     = busy && conv_done;
    assign keep_going = repeat_en && !chunk_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            cur_grp  <= GRP_REG;
            reg_run  <= 1'b0;
            inj_run  <= 1'b0;
            reg_idx  <= '0;
            inj_idx  <= '0;
            reg_cnt  <= '0;
            conv_req <= 1'b0;
            conv_ch  <= '0;
        end else begin
            conv_req <= 1'b0;
            if (issue) begin
                conv_req <= 1'b1;
                busy     <= 1'b1;
                if (inj_run) begin
                    cur_grp <= GRP_INJ;
                    conv_ch <= inj_seq[inj_idx*CH_W +: CH_W];
                end else begin
                    cur_grp <= GRP_REG;
                    conv_ch <= reg_seq[reg_idx*CH_W +: CH_W];
                end
            end
            if (finish) begin
                busy <= 1'b0;
                if (cur_grp == GRP_INJ) begin
                    if (inj_last) begin
                        inj_idx <= '0;
                        inj_run <= 1'b0;
                    end else begin
                        inj_idx <= inj_idx + 1'b1;
                        if (inj_step_en) inj_run <= 1'b0;
                    end
                end else begin
                    reg_cnt <= reg_cnt + 1'b1;
                    if (reg_last) reg_idx <= '0;
                    else          reg_idx <= reg_idx + 1'b1;
                    if (reg_last && inj_after_reg) begin
                        inj_run <= 1'b1;
                        if (!inj_step_en) inj_idx <= '0;
                    end
                    if (chunk_end || (reg_last && !keep_going)) begin
                        reg_run <= 1'b0;
                        reg_cnt <= '0;
                    end
                end
            end
            if (reg_go && !reg_run) begin
                reg_run <= 1'b1;
                reg_cnt <= '0;
                if (!chunk_en) reg_idx <= '0;
            end
            if (inj_go && !inj_after_reg && !inj_run) begin
                inj_run <= 1'b1;
                if (!inj_step_en) inj_idx <= '0;
            end
        end
    end

    always_comb begin
        evt.wr_reg       = finish && (cur_grp == GRP_REG);
        evt.wr_inj       = finish && (cur_grp == GRP_INJ);
        evt.reg_list_end = finish && (cur_grp == GRP_REG) && reg_last;
        evt.inj_list_end = finish && (cur_grp == GRP_INJ) && inj_last;
    end
    assign evt_slot = inj_idx;

    // R3: a request lasts a single cycle
    a_r3_req_single: assert property (@(posedge clk) disable iff (rst)
        conv_req |=> !conv_req);

    // R3: no second request while one is outstanding
    a_r3_one_outstanding: assert property (@(posedge clk) disable iff (rst)
        (busy && !conv_done) |=> !conv_req);

    // R6: a pending injected list wins the next free slot
    a_r6_inj_first: assert property (@(posedge clk) disable iff (rst)
        (!busy && inj_run) |=> (conv_req && cur_grp == GRP_INJ));

    // R5: a chunk never runs past its size
    a_r5_chunk_bound: assert property (@(posedge clk) disable iff (rst)
        (reg_run && chunk_en) |-> (reg_cnt <= chunk_m1));

endmodule

// File: rtl/seq_results.sv
module seq_results
    import seq_pkg::*;
#(
    parameter int DATA_W    = DATA_W_DEF,
    parameter int INJ_SLOTS = INJ_SLOTS_DEF,
    localparam int IIDX_W   = $clog2(INJ_SLOTS)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  done_evt_t                   evt,
    input  logic [IIDX_W-1:0]           evt_slot,
    input  logic [DATA_W-1:0]           conv_data,
    input  logic                        eoc_per_conv,
    input  logic                        dr_read,
    input  logic                        eoc_clr,
    input  logic                        inj_eoc_clr,
    input  logic                        overrun_clr,
    output logic [DATA_W-1:0]           reg_data,
    output logic [INJ_SLOTS*DATA_W-1:0] inj_data,
    output logic                        eoc,
    output logic                        inj_eoc,
    output logic                        overrun
);

    logic unread;
    logic [DATA_W-1:0] inj_q [INJ_SLOTS];

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_data <= '0;
            unread   <= 1'b0;
        end else if (evt.wr_reg) begin
            reg_data <= conv_data;
            unread   <= 1'b1;
        end else if (dr_read) begin
            unread   <= 1'b0;
        end
    end

    generate
        for (genvar k = 0; k < INJ_SLOTS; k++) begin : g_inj
            always_ff @(posedge clk) begin
                if (rst)
                    inj_q[k] <= '0;
                else if (evt.wr_inj && evt_slot == IIDX_W'(k))
                    inj_q[k] <= conv_data;
            end
            assign inj_data[k*DATA_W +: DATA_W] = inj_q[k];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            eoc     <= 1'b0;
            inj_eoc <= 1'b0;
            overrun <= 1'b0;
        end else begin
            if (evt.wr_reg && (eoc_per_conv || evt.reg_list_end)) eoc <= 1'b1;
            else if (eoc_clr)                                     eoc <= 1'b0;
            if (evt.inj_list_end)  inj_eoc <= 1'b1;
            else if (inj_eoc_clr)  inj_eoc <= 1'b0;
            if (evt.wr_reg && unread && !dr_read) overrun <= 1'b1;
            else if (overrun_clr)                 overrun <= 1'b0;
        end
    end

    // R13: flags hold until cleared
    a_r13_eoc_sticky: assert property (@(posedge clk) disable iff (rst)
        (eoc && !eoc_clr) |=> eoc);
    a_r13_ovr_sticky: assert property (@(posedge clk) disable iff (rst)
        (overrun && !overrun_clr) |=> overrun);

    // R12: overrun rises only on a write over an unread result
    a_r12_ovr_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> $past(evt.wr_reg && unread));

    // R11: injected-end flag rises only at a list end
    a_r11_inj_end_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(inj_eoc) |-> $past(evt.inj_list_end));

endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
    import seq_pkg::*;
#(
    parameter int CH_W      = CH_W_DEF,
    parameter int DATA_W    = DATA_W_DEF,
    parameter int REG_SLOTS = REG_SLOTS_DEF,
    parameter int INJ_SLOTS = INJ_SLOTS_DEF,
    parameter int CHUNK_W   = CHUNK_W_DEF,
    localparam int RIDX_W   = $clog2(REG_SLOTS),
    localparam int IIDX_W   = $clog2(INJ_SLOTS)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        scan_en,
    input  logic                        repeat_en,
    input  logic                        chunk_en,
    input  logic [CHUNK_W-1:0]          chunk_m1,
    input  logic                        inj_step_en,
    input  logic                        inj_after_reg,
    input  logic                        eoc_per_conv,
    input  logic [RIDX_W-1:0]           reg_len,
    input  logic [REG_SLOTS*CH_W-1:0]   reg_seq,
    input  logic [IIDX_W-1:0]           inj_len,
    input  logic [INJ_SLOTS*CH_W-1:0]   inj_seq,
    input  logic [1:0]                  reg_edge,
    input  logic [1:0]                  inj_edge,
    input  logic                        reg_sw_start,
    input  logic                        inj_sw_start,
    input  logic                        reg_ext_trig,
    input  logic                        inj_ext_trig,
    output logic                        conv_req,
    output logic [CH_W-1:0]             conv_ch,
    input  logic                        conv_done,
    input  logic [DATA_W-1:0]           conv_data,
    output logic [DATA_W-1:0]           reg_data,
    output logic [INJ_SLOTS*DATA_W-1:0] inj_data,
    input  logic                        dr_read,
    output logic                        eoc,
    output logic                        inj_eoc,
    output logic                        overrun,
    input  logic                        eoc_clr,
    input  logic                        inj_eoc_clr,
    input  logic                        overrun_clr
);

    localparam int N_GRP = 2;

    logic [1:0] grp_mode [N_GRP];
    logic       grp_ext  [N_GRP];
    logic       grp_sw   [N_GRP];
    logic       grp_go   [N_GRP];

    assign grp_mode[0] = reg_edge;
    assign grp_mode[1] = inj_edge;
    assign grp_ext[0]  = reg_ext_trig;
    assign grp_ext[1]  = inj_ext_trig;
    assign grp_sw[0]   = reg_sw_start;
    assign grp_sw[1]   = inj_sw_start;

    generate
        for (genvar g = 0; g < N_GRP; g++) begin : g_trig
            seq_trig_edge u_trig (
                .clk    (clk),
                .rst    (rst),
                .mode   (grp_mode[g]),
                .ext_in (grp_ext[g]),
                .sw_in  (grp_sw[g]),
                .go     (grp_go[g])
            );
        end
    endgenerate

    done_evt_t         evt;
    logic [IIDX_W-1:0] evt_slot;

    seq_sched #(
        .CH_W      (CH_W),
        .REG_SLOTS (REG_SLOTS),
        .INJ_SLOTS (INJ_SLOTS),
        .CHUNK_W   (CHUNK_W)
    ) u_sched (
        .clk           (clk),
        .rst           (rst),
        .scan_en       (scan_en),
        .repeat_en     (repeat_en),
        .chunk_en      (chunk_en),
        .chunk_m1      (chunk_m1),
        .inj_step_en   (inj_step_en),
        .inj_after_reg (inj_after_reg),
        .reg_len       (reg_len),
        .reg_seq       (reg_seq),
        .inj_len       (inj_len),
        .inj_seq       (inj_seq),
        .reg_go        (grp_go[0]),
        .inj_go        (grp_go[1]),
        .conv_done     (conv_done),
        .conv_req      (conv_req),
        .conv_ch       (conv_ch),
        .evt           (evt),
        .evt_slot      (evt_slot)
    );

    seq_results #(
        .DATA_W    (DATA_W),
        .INJ_SLOTS (INJ_SLOTS)
    ) u_results (
        .clk          (clk),
        .rst          (rst),
        .evt          (evt),
        .evt_slot     (evt_slot),
        .conv_data    (conv_data),
        .eoc_per_conv (eoc_per_conv),
        .dr_read      (dr_read),
        .eoc_clr      (eoc_clr),
        .inj_eoc_clr  (inj_eoc_clr),
        .overrun_clr  (overrun_clr),
        .reg_data     (reg_data),
        .inj_data     (inj_data),
        .eoc          (eoc),
        .inj_eoc      (inj_eoc),
        .overrun      (overrun)
    );

endmodule

// File: tb/conv_sequencer_test.sv
module conv_sequencer_test;

    localparam int CLK_P = 10;
    localparam int LAT   = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        scan_en, repeat_en, chunk_en, inj_step_en, inj_after_reg, eoc_per_conv;
    logic [2:0]  chunk_m1;
    logic [3:0]  reg_len;
    logic [79:0] reg_seq;
    logic [1:0]  inj_len;
    logic [19:0] inj_seq;
    logic [1:0]  reg_edge, inj_edge;
    logic        reg_sw_start, inj_sw_start, reg_ext_trig, inj_ext_trig;
    logic        conv_req;
    logic [4:0]  conv_ch;
    logic        conv_done;
    logic [11:0] conv_data;
    logic [11:0] reg_data;
    logic [47:0] inj_data;
    logic        dr_read, eoc, inj_eoc, overrun, eoc_clr, inj_eoc_clr, overrun_clr;

    always #(CLK_P/2) clk = ~clk;

    conv_sequencer uut (
        .clk(clk), .rst(rst), .scan_en(scan_en), .repeat_en(repeat_en),
        .chunk_en(chunk_en), .chunk_m1(chunk_m1), .inj_step_en(inj_step_en),
        .inj_after_reg(inj_after_reg), .eoc_per_conv(eoc_per_conv),
        .reg_len(reg_len), .reg_seq(reg_seq), .inj_len(inj_len), .inj_seq(inj_seq),
        .reg_edge(reg_edge), .inj_edge(inj_edge), .reg_sw_start(reg_sw_start),
        .inj_sw_start(inj_sw_start), .reg_ext_trig(reg_ext_trig),
        .inj_ext_trig(inj_ext_trig), .conv_req(conv_req), .conv_ch(conv_ch),
        .conv_done(conv_done), .conv_data(conv_data), .reg_data(reg_data),
        .inj_data(inj_data), .dr_read(dr_read), .eoc(eoc), .inj_eoc(inj_eoc),
        .overrun(overrun), .eoc_clr(eoc_clr), .inj_eoc_clr(inj_eoc_clr),
        .overrun_clr(overrun_clr)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    int n_req = 0;
    int ch_log [64];
    int dat_log [64];
    int exp_ch [64];
    int exp_n;
    int tag_ctr = 0;

    function automatic int mk_data(input int ch, input int tag);
        return ((ch & 31) << 7) | (tag & 127);
    endfunction

    function automatic int rch(input int i);
        return int'(reg_seq[i*5 +: 5]);
    endfunction

    function automatic int ich(input int i);
        return int'(inj_seq[i*5 +: 5]);
    endfunction

    function automatic int inj_val(input int k);
        return int'(inj_data[k*12 +: 12]);
    endfunction

    // fixed-latency engine model plus request log
    initial begin
        int cnt;
        bit pend;
        int held;
        pend = 0; cnt = 0; held = 0;
        conv_done = 1'b0;
        conv_data = '0;
        forever begin
            @(negedge clk);
            conv_done = 1'b0;
            if (pend) begin
                if (cnt == 0) begin
                    conv_done = 1'b1;
                    conv_data = 12'(held);
                    pend = 0;
                end else begin
                    cnt = cnt - 1;
                end
            end
            if (conv_req) begin
                held = mk_data(int'(conv_ch), tag_ctr);
                tag_ctr = tag_ctr + 1;
                if (n_req < 64) begin
                    ch_log[n_req]  = int'(conv_ch);
                    dat_log[n_req] = held;
                end
                n_req = n_req + 1;
                pend = 1;
                cnt = LAT;
            end
        end
    end

    task automatic check_eq(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic settle(input int nconv);
        tick(nconv * (LAT + 6) + 10);
    endtask

    task automatic wait_req(input int target);
        for (int w = 0; w < 400 && n_req < target; w++) @(negedge clk);
    endtask

    task automatic pulse_reg;
        @(negedge clk) reg_sw_start = 1'b1;
        @(negedge clk) reg_sw_start = 1'b0;
    endtask

    task automatic pulse_inj;
        @(negedge clk) inj_sw_start = 1'b1;
        @(negedge clk) inj_sw_start = 1'b0;
    endtask

    task automatic clear_all;
        @(negedge clk);
        eoc_clr = 1'b1; inj_eoc_clr = 1'b1; overrun_clr = 1'b1; dr_read = 1'b1;
        @(negedge clk);
        eoc_clr = 1'b0; inj_eoc_clr = 1'b0; overrun_clr = 1'b0; dr_read = 1'b0;
        n_req = 0;
    endtask

    task automatic verify_seq(input string what);
        check_eq({what, " count"}, n_req, exp_n);
        for (int i = 0; i < exp_n && i < n_req && i < 64; i++)
            check_eq({what, " channel"}, ch_log[i], exp_ch[i]);
    endtask

    task automatic randomize_lists;
        for (int i = 0; i < 16; i++) reg_seq[i*5 +: 5] = 5'($urandom % 32);
        for (int i = 0; i < 4; i++)  inj_seq[i*5 +: 5] = 5'($urandom % 32);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #(CLK_P * 60000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary;
            $finish;
        end
    end

    initial begin
        int seed_sink;
        int len;
        int idx;
        int cnt;
        int e;
        int dn;
        seed_sink = $urandom(32'd2024);
        rst = 1'b1;
        scan_en = 0; repeat_en = 0; chunk_en = 0; inj_step_en = 0; inj_after_reg = 0;
        eoc_per_conv = 0; chunk_m1 = '0; reg_len = '0; inj_len = '0;
        reg_seq = '0; inj_seq = '0; reg_edge = '0; inj_edge = '0;
        reg_sw_start = 0; inj_sw_start = 0; reg_ext_trig = 0; inj_ext_trig = 0;
        dr_read = 0; eoc_clr = 0; inj_eoc_clr = 0; overrun_clr = 0;
        tick(4);
        rst = 1'b0;
        tick(2);

        // R1 reset state
        check_eq("R1 conv_req", int'(conv_req), 0);
        check_eq("R1 reg_data", int'(reg_data), 0);
        check_eq("R1 inj_data", int'(inj_data != '0), 0);
        check_eq("R1 flags", int'({eoc, inj_eoc, overrun}), 0);

        randomize_lists;

        // R3 single slot with scan off, R10 list end flag, R9 data
        clear_all;
        reg_len = 4'd5;
        pulse_reg;
        settle(2);
        exp_n = 1; exp_ch[0] = rch(0);
        verify_seq("R3 scan off");
        check_eq("R10 eoc after single", int'(eoc), 1);
        check_eq("R9 reg_data single", int'(reg_data), dat_log[0]);

        // R3 R9 R10 R12 constrained random scan runs
        scan_en = 1;
        for (int it = 0; it < 6; it++) begin
            randomize_lists;
            len = (it == 0) ? 15 : int'($urandom % 16);
            reg_len = 4'(len);
            eoc_per_conv = 1'($urandom % 2);
            clear_all;
            pulse_reg;
            if (len >= 1) begin
                wait_req(2);
                tick(1);
                check_eq("R10 eoc after first conversion", int'(eoc), int'(eoc_per_conv));
            end
            settle(len + 1);
            exp_n = len + 1;
            for (int i = 0; i <= len; i++) exp_ch[i] = rch(i);
            verify_seq("R3 scan order");
            check_eq("R10 eoc at list end", int'(eoc), 1);
            check_eq("R9 reg_data last", int'(reg_data), dat_log[len]);
            check_eq("R12 overrun unread", int'(overrun), (len >= 1) ? 1 : 0);
        end

        // R12 reading keeps overrun clear
        eoc_per_conv = 0;
        reg_len = 4'd3;
        clear_all;
        dr_read = 1'b1;
        pulse_reg;
        settle(4);
        check_eq("R12 overrun with reads", int'(overrun), 0);
        dr_read = 1'b0;

        // R2 regular trigger edge modes
        scan_en = 0;
        for (int m = 0; m < 4; m++) begin
            reg_edge = 2'(m);
            clear_all;
            @(negedge clk) reg_ext_trig = 1'b1;
            settle(2);
            @(negedge clk) reg_ext_trig = 1'b0;
            settle(2);
            check_eq("R2 regular edge mode count", n_req, (m == 1 || m == 2) ? 1 : ((m == 3) ? 2 : 0));
        end
        reg_edge = 2'b00;

        // R2 injected falling edge, R11 injected end
        inj_edge = 2'b10;
        inj_len = 2'd0;
        clear_all;
        @(negedge clk) inj_ext_trig = 1'b1;
        settle(2);
        check_eq("R2 injected rising ignored in falling mode", n_req, 0);
        @(negedge clk) inj_ext_trig = 1'b0;
        settle(2);
        exp_n = 1; exp_ch[0] = ich(0);
        verify_seq("R2 injected falling edge");
        check_eq("R11 inj_eoc single slot", int'(inj_eoc), 1);
        check_eq("R9 injected slot 0 data", inj_val(0), dat_log[0]);
        inj_edge = 2'b00;

        // R4 repeat mode stops at list end after clearing
        scan_en = 1; reg_len = 4'd2; repeat_en = 1;
        clear_all;
        pulse_reg;
        wait_req(7);
        repeat_en = 0;
        settle(5);
        exp_n = 9;
        for (int i = 0; i < 9; i++) exp_ch[i] = rch(i % 3);
        verify_seq("R4 repeat");

        // R5 chunked regular runs
        chunk_en = 1;
        len = 3 + int'($urandom % 5);
        dn = int'($urandom % 3);
        reg_len = 4'(len);
        chunk_m1 = 3'(dn);
        clear_all;
        idx = 0; e = 0;
        for (int t = 0; t < 5; t++) begin
            pulse_reg;
            settle(dn + 2);
            cnt = 0;
            while (1) begin
                exp_ch[e] = rch(idx);
                e++; cnt++;
                if (idx == len) begin idx = 0; break; end
                idx++;
                if (cnt == dn + 1) break;
            end
        end
        exp_n = e;
        verify_seq("R5 chunk walk");
        chunk_en = 0;

        // R14 start during a run is ignored
        reg_len = 4'd3;
        clear_all;
        pulse_reg;
        wait_req(2);
        pulse_reg;
        settle(5);
        check_eq("R14 extra start ignored", n_req, 4);

        // R6 injected preemption, R9 injected registers, R11
        inj_len = 2'd1;
        clear_all;
        pulse_reg;
        wait_req(2);
        pulse_inj;
        settle(7);
        exp_n = 6;
        exp_ch[0] = rch(0); exp_ch[1] = rch(1); exp_ch[2] = ich(0);
        exp_ch[3] = ich(1); exp_ch[4] = rch(2); exp_ch[5] = rch(3);
        verify_seq("R6 preempt order");
        check_eq("R9 injected slot 0", inj_val(0), dat_log[2]);
        check_eq("R9 injected slot 1", inj_val(1), dat_log[3]);
        check_eq("R9 regular after resume", int'(reg_data), dat_log[5]);
        check_eq("R11 inj_eoc after list", int'(inj_eoc), 1);

        // R7 inject after regular list
        inj_after_reg = 1;
        reg_len = 4'd1; inj_len = 2'd2;
        clear_all;
        pulse_inj;
        settle(2);
        check_eq("R7 injected start ignored", n_req, 0);
        pulse_reg;
        settle(6);
        exp_n = 5;
        exp_ch[0] = rch(0); exp_ch[1] = rch(1);
        exp_ch[2] = ich(0); exp_ch[3] = ich(1); exp_ch[4] = ich(2);
        verify_seq("R7 auto injected");
        inj_after_reg = 0;

        // R8 stepping injected list, R11 flag only at last slot
        inj_step_en = 1;
        clear_all;
        pulse_inj; settle(2);
        pulse_inj; settle(2);
        check_eq("R11 no inj_eoc mid list", int'(inj_eoc), 0);
        pulse_inj; settle(2);
        check_eq("R11 inj_eoc at last slot", int'(inj_eoc), 1);
        pulse_inj; settle(2);
        exp_n = 4;
        exp_ch[0] = ich(0); exp_ch[1] = ich(1); exp_ch[2] = ich(2); exp_ch[3] = ich(0);
        verify_seq("R8 one slot per start");
        inj_step_en = 0;

        // R13 flags stay until cleared
        scan_en = 0;
        clear_all;
        pulse_reg;
        settle(2);
        tick(30);
        check_eq("R13 eoc held", int'(eoc), 1);
        @(negedge clk) eoc_clr = 1'b1;
        @(negedge clk) eoc_clr = 1'b0;
        check_eq("R13 eoc cleared", int'(eoc), 0);

        finished = 1;
        summary;
        $finish;
    end

endmodule